// File: doc/BRIEF.md
# Sensor Fault Supervisor

This block watches a sensor interface and records faults in one sticky latch. It has three fault sources. The first is a low-voltage flag from an analog comparator. The second is a monitored sensor clock, whose frequency is measured against the local reference clock. The third is a bus of trim bits, which must hold an even number of ones. Once any source raises a fault, the latch stays set until it is explicitly cleared, even if the source goes quiet.

One active-high self-test input does two jobs. First, it is echoed straight onto the single status output, so board wiring between the two pins can be checked at any time. Second, it clears the latch. The clear takes effect only when self-test is held high for a qualified minimum time, and only if no fault source is active at that moment. The status output is not trusted until self-test has risen at least once after reset; until then it reads low and a valid flag stays low. A separate sticky bit per cause is brought out for debug.

The asynchronous inputs are the low-voltage flag, the monitored clock and self-test. Each passes through a two-flop synchronizer into the reference domain. The trim bits are static configuration and are sampled directly. Timing limits are given in microseconds and kilohertz, and the block converts them into reference-clock cycle counts.

Top module: `sensor_fault_supervisor`

## Requirements
- R1: Whenever the synchronized self-test input is high, `status_o` is high, whatever the latch state; the echo follows `st_i` after two reference clock edges.
- R2: A high `lvd_i` sets the fault latch and debug cause bit 0 of `cause_o`.
- R3: An odd number of ones on `trim_i` sets the fault latch and debug cause bit 2 of `cause_o`.
- R4: Rising edges of `mon_clk_i` are counted over windows of WIN_US microseconds. A window with fewer than MON_MIN_KHZ*WIN_US/1000 edges (zero included) or more than MON_MAX_KHZ*WIN_US/1000 edges sets debug cause bit 1. The verdict of one window holds until the next window ends.
- R5: Until the first rising edge of the synchronized self-test after reset, `status_valid_o` is low and `status_o` is low even with the latch set. After that edge, `status_valid_o` is high and `status_o` reflects the latch.
- R6: The latch clears only after self-test has been high for CLR_US microseconds without a break. Any shorter high pulse leaves every cause bit unchanged, and each falling edge restarts the qualification.
- R7: A qualified clear has no effect while any fault source is still active.
- R8: `rst_ni` low clears all cause bits, the valid flag, the status output and all counters.
- R9: Cause bits stay set after their source goes inactive, until a qualified clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lvd_i | input | 1 | Low-voltage flag, asynchronous |
| mon_clk_i | input | 1 | Monitored sensor clock, asynchronous |
| trim_i | input | TRIM_W | Trim/configuration bits checked for even parity |
| st_i | input | 1 | Active-high self-test, asynchronous |
| status_o | output | 1 | Fault latch ORed with self-test |
| status_valid_o | output | 1 | High once self-test has risen since reset |
| cause_o | output | 3 | Sticky causes: bit 0 low voltage, bit 1 clock, bit 2 parity |

## Verification
The hardest state to reach from the ports is a qualified clear blocked by a clock fault. The clock verdict comes only from a full measurement window, so the fault stays asserted for up to a window after the clock recovers. The bench drives the monitored clock from a generator whose half period can be changed at run time. It then holds each slow, fast or stopped setting for more than two windows before checking the cause bit. After restoring the nominal rate, it waits more than two windows before the long self-test pulse. Pulses just under and well over the qualification length, applied while a fault persists and after it goes away, separate R6 from R7.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NCAUSE = 3;
  typedef enum int unsigned {
    CAUSE_LVD = 0,
    CAUSE_CLK = 1,
    CAUSE_PAR = 2
  } cause_e;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fsup_clk_mon.sv
module fsup_clk_mon #(
  parameter int WIN_CYC   = 100,
  parameter int MIN_EDGES = 5,
  parameter int MAX_EDGES = 26
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_s_i,
  output logic bad_o
);
  localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam int CW = $clog2(WIN_CYC + 1);

  logic          mon_q;
  logic          rise;
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] edge_cnt;
  logic [CW-1:0] edge_tot;
  logic          win_end;

  assign rise     = mon_s_i & ~mon_q;
  assign win_end  = (win_cnt == WW'(WIN_CYC - 1));
  assign edge_tot = edge_cnt + CW'(rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q    <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      bad_o    <= 1'b0;
    end else begin
      mon_q <= mon_s_i;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
        bad_o    <= (int'(edge_tot) < MIN_EDGES) || (int'(edge_tot) > MAX_EDGES);
      end else begin
        win_cnt  <= win_cnt + WW'(1);
        edge_cnt <= edge_tot;
      end
    end
  end

  // edges within a window can never exceed the window length
  p_edge_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(edge_cnt) <= WIN_CYC);
endmodule

// File: rtl/fsup_st_qual.sv
module fsup_st_qual #(
  parameter int CLR_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic st_s_i,
  output logic rise_o,
  output logic done_o
);
  localparam int QW = $clog2(CLR_CYC + 1);

  logic          st_q;
  logic [QW-1:0] cnt;

  assign rise_o = st_s_i & ~st_q;
  assign done_o = st_s_i && (cnt == QW'(CLR_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= 1'b0;
      cnt  <= '0;
    end else begin
      st_q <= st_s_i;
      if (!st_s_i)                  cnt <= '0;
      else if (cnt != QW'(CLR_CYC)) cnt <= cnt + QW'(1);
    end
  end

  // qualification only completes on an unbroken high run
  p_done_after_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st_s_i));
  p_restart_on_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_s_i |=> !done_o);
endmodule

// File: rtl/sensor_fault_supervisor.sv
module sensor_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int TRIM_W      = 8,
  parameter int REF_CLK_KHZ = 250000,
  parameter int CLR_US      = 100,
  parameter int WIN_US      = 100,
  parameter int MON_MIN_KHZ = 50,
  parameter int MON_MAX_KHZ = 260
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvd_i,
  input  logic              mon_clk_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              st_i,
  output logic              status_o,
  output logic              status_valid_o,
  output logic [2:0]        cause_o
);
  localparam int CLR_CYC   = REF_CLK_KHZ * CLR_US / 1000;
  localparam int WIN_CYC   = REF_CLK_KHZ * WIN_US / 1000;
  localparam int MIN_RAW   = MON_MIN_KHZ * WIN_US / 1000;
  localparam int MIN_EDGES = (MIN_RAW < 1) ? 1 : MIN_RAW;
  localparam int MAX_EDGES = MON_MAX_KHZ * WIN_US / 1000;

  logic [2:0]        async_s;
  logic              lvd_s, mon_s, st_s;
  logic              clk_bad, par_odd;
  logic              st_rise, qual_done;
  logic [NCAUSE-1:0] src, cause_q;
  logic              fault_any, clr_ok, latch, valid_q;

  fsup_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({st_i, mon_clk_i, lvd_i}),
    .q_o   (async_s)
  );
  assign {st_s, mon_s, lvd_s} = async_s;

  fsup_clk_mon #(
    .WIN_CYC  (WIN_CYC),
    .MIN_EDGES(MIN_EDGES),
    .MAX_EDGES(MAX_EDGES)
  ) u_clk_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mon_s_i(mon_s),
    .bad_o  (clk_bad)
  );

  fsup_st_qual #(.CLR_CYC(CLR_CYC)) u_st_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .st_s_i(st_s),
    .rise_o(st_rise),
    .done_o(qual_done)
  );

  assign par_odd        = ^trim_i;
  assign src[CAUSE_LVD] = lvd_s;
  assign src[CAUSE_CLK] = clk_bad;
  assign src[CAUSE_PAR] = par_odd;
  assign fault_any      = |src;
  assign clr_ok         = qual_done & ~fault_any;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q[i] <= 1'b0;
      else         cause_q[i] <= src[i] | (cause_q[i] & ~clr_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (st_rise) valid_q <= 1'b1;
  end

  assign latch          = |cause_q;
  assign status_o       = st_s | (valid_q & latch);
  assign status_valid_o = valid_q;
  assign cause_o        = cause_q;

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(latch) && !$past(st_s)) |-> latch);
  p_clear_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch) |-> $past(qual_done));
  p_clear_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |=> latch);
  p_valid_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(st_s));
  p_parity_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_odd |=> cause_q[CAUSE_PAR]);
  p_lvd_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_s |=> cause_q[CAUSE_LVD]);
endmodule

// File: tb/sensor_fault_supervisor_bench.sv
`timescale 1ns/1ps
module sensor_fault_supervisor_bench;
  localparam int TRIM_W = 8;
  localparam int CLR    = 100;  // cycles with REF_CLK_KHZ=1000, CLR_US=100
  localparam int NVEC   = 6;
  // {trim, expected parity cause}
  localparam logic [8:0] VEC [NVEC] = '{
    {8'h00, 1'b0}, {8'h01, 1'b1}, {8'h03, 1'b0},
    {8'h80, 1'b1}, {8'hFF, 1'b0}, {8'hFE, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lvd = 1'b0;
  logic              mon_clk = 1'b0;
  logic [TRIM_W-1:0] trim = '0;
  logic              st = 1'b0;
  logic              status, status_valid;
  logic [2:0]        cause;

  int n_run = 0;
  int n_fail = 0;
  int mon_half = 7;
  bit mon_stop = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  initial begin
    #1;
    forever begin
      if (mon_stop) mon_clk = 1'b0;
      else          mon_clk = ~mon_clk;
      #(mon_half * 4);
    end
  end

  sensor_fault_supervisor #(
    .TRIM_W(TRIM_W), .REF_CLK_KHZ(1000), .CLR_US(100), .WIN_US(100),
    .MON_MIN_KHZ(50), .MON_MAX_KHZ(260)
  ) u_sensor_fault_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .lvd_i(lvd), .mon_clk_i(mon_clk),
    .trim_i(trim), .st_i(st), .status_o(status),
    .status_valid_o(status_valid), .cause_o(cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic st_pulse(input int n);
    st = 1'b1;
    tick(n);
    st = 1'b0;
  endtask

  task automatic clear_ok(input string req);
    st_pulse(CLR + 5);
    tick(4);
    check(req, 32'(cause), 32'd0);
  endtask

  task automatic clk_case(input int half, input bit stop, input string tag);
    mon_half = half;
    mon_stop = stop;
    tick(250);
    check({"R4 clock fault ", tag}, 32'(cause[1]), 32'd1);
    mon_half = 7;
    mon_stop = 1'b0;
    tick(250);
    clear_ok({"R4 recover ", tag});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R8 reset state
    check("R8 reset status", 32'(status), 32'd0);
    check("R8 reset valid", 32'(status_valid), 32'd0);
    check("R8 reset cause", 32'(cause), 32'd0);
    rst_n = 1'b1;
    tick(250);

    // R2 / R5: fault before any self-test edge stays invisible on status
    lvd = 1'b1;
    tick(5);
    check("R2 lvd cause", 32'(cause), 32'd1);
    check("R5 status held low", 32'(status), 32'd0);
    check("R5 valid low", 32'(status_valid), 32'd0);

    // R1 echo during short pulse; R6 short pulse keeps latch
    st = 1'b1;
    tick(3);
    check("R1 echo high", 32'(status), 32'd1);
    tick(20);
    st = 1'b0;
    tick(4);
    check("R5 valid after rise", 32'(status_valid), 32'd1);
    check("R6 short pulse keeps", 32'(cause), 32'd1);
    check("R5 status shows latch", 32'(status), 32'd1);

    // R6 just under threshold
    st_pulse(CLR - 5);
    tick(4);
    check("R6 under threshold", 32'(cause), 32'd1);
    lvd = 1'b0;
    st_pulse(CLR - 5);
    tick(4);
    check("R6 under threshold no fault", 32'(cause), 32'd1);
    lvd = 1'b1;
    tick(4);

    // R7 long pulse while fault persists
    st_pulse(CLR + 5);
    tick(4);
    check("R7 blocked by lvd", 32'(cause), 32'd1);

    // R9 sticky after source drops, then R6 clear
    lvd = 1'b0;
    tick(10);
    check("R9 sticky", 32'(cause), 32'd1);
    clear_ok("R6 long pulse clears");
    check("R6 status low after clear", 32'(status), 32'd0);

    // R1 echo with latch clear
    st = 1'b1;
    tick(3);
    check("R1 echo clean latch", 32'(status), 32'd1);
    st = 1'b0;
    tick(3);
    check("R1 echo released", 32'(status), 32'd0);

    // R3 parity table
    for (int i = 0; i < NVEC; i++) begin
      trim = VEC[i][8:1];
      tick(3);
      check("R3 parity cause", 32'(cause[2]), 32'(VEC[i][0]));
      if (VEC[i][0]) begin
        st_pulse(CLR + 5);
        tick(4);
        check("R7 blocked by parity", 32'(cause[2]), 32'd1);
        trim = '0;
        clear_ok("R3 parity cleared");
      end else begin
        check("R3 even no fault", 32'(cause), 32'd0);
      end
    end
    trim = '0;

    // R4 clock monitor: slow, fast, stopped
    clk_case(20, 1'b0, "slow");
    clk_case(1, 1'b0, "fast");
    clk_case(7, 1'b1, "stopped");
    tick(250);
    check("R4 nominal no fault", 32'(cause), 32'd0);

    // R8 mid-run reset
    lvd = 1'b1;
    tick(5);
    check("R2 lvd again", 32'(cause[0]), 32'd1);
    rst_n = 1'b0;
    tick(1);
    check("R8 reset clears cause", 32'(cause), 32'd0);
    check("R8 reset clears valid", 32'(status_valid), 32'd0);
    check("R8 reset clears status", 32'(status), 32'd0);
    lvd = 1'b0;
    rst_n = 1'b1;
    tick(5);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule